// File: doc/BRIEF.md
# GPIO Port with Per-Pin Function Select

An eight-pin general-purpose I/O port in which any pin can be given up to a fixed, dedicated interrupt-input role. Software uses a small register bus with three registers: a data latch, an output-direction mask and a mode mask. While a pin is in GPIO mode, its direction bit decides whether the latch drives the pad. While a pin is in dedicated mode, the port stops driving it and forwards its level to that pin's interrupt-request output.

The pad is modelled as three separate vectors: output value, output enable and input level. Every input level passes through a multi-flop synchroniser first. Reads of the data register return the synchronised pad level, never the latch. As a result, a value written to an input pin is kept unseen in the latch. It shows up on the pad only when that pin is switched to output.

Top module: `gpio_fsel_port`

## Requirements
- R1: While reset is low the data latch holds all ones, the direction mask holds all zeros and the mode mask holds all ones. So just after reset, pin_o = 0xFF, pin_oe_o = 0x00 and fn_req_o = 0x00.
- R2: The register offsets are 0 for data, 1 for direction and 2 for mode. Offset 3 reads as 0x00, and a write to offset 3 changes no register and no output.
- R3: pin_oe_o bit i is 1 exactly when mode bit i is 1 (GPIO) and direction bit i is 1 (output). A pin in dedicated mode (mode bit 0) is never driven.
- R4: A write to offset 0 updates the data latch at the next clock edge, whatever the direction. pin_o always carries the latch. A bit written while it is an input reaches the pad once its direction bit is set.
- R5: A read at offset 0 returns the pad level as it was sampled two clock edges earlier. For an output pin this equals the driven latch bit once two edges have passed since it began to drive.
- R6: fn_req_o bit i equals the synchronised level of pin i while mode bit i is 0. It is 0 while mode bit i is 1.
- R7: The dedicated lines are fixed by position: fn_req_o bits 0 to 3 are interrupt inputs 0 to 3, and bits 4, 5, 6 and 7 are interrupt levels 1, 2, 3 and 6.
- R8: Writes to offsets 1 and 2 take effect at the next clock edge, and reads at those offsets return the stored mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| pin_i | input | 8 | Pad input level |
| pin_o | output | 8 | Pad output value (data latch) |
| pin_oe_o | output | 8 | Pad output enable |
| fn_req_o | output | 8 | Dedicated interrupt-request lines, one per pin |

## Verification
The embedded properties check on every cycle that the enable never rises on a dedicated or input pin, that request lines stay quiet in GPIO mode, that register writes land in the next cycle, that offset 3 leaves all state alone, and that reset leaves the specified values. Three things can only be shown by the bench's scenarios, compared each cycle against a behavioural model: the two-edge latency from pad to readback and to request line, a value written to an input later appearing on the pad, and the live pad level being returned rather than the latch.

// File: rtl/gpio_fsel_pkg.sv
package gpio_fsel_pkg;
   localparam int unsigned REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      OFS_DATA = 2'd0,
      OFS_DIR  = 2'd1,
      OFS_MODE = 2'd2,
      OFS_RSVD = 2'd3
   } reg_ofs_e;
endpackage

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
   import gpio_fsel_pkg::*;
#(
   parameter int unsigned         W        = 8,
   parameter logic [W-1:0]        DATA_RST = '1,
   parameter logic [W-1:0]        DIR_RST  = '0,
   parameter logic [W-1:0]        MODE_RST = '1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  wr_en_i,
   input  logic [REG_ADDR_W-1:0] addr_i,
   input  logic [W-1:0]          wdata_i,
   output logic [W-1:0]          data_q,
   output logic [W-1:0]          dir_q,
   output logic [W-1:0]          mode_q
);
   logic wr_data, wr_dir, wr_mode;

   always_comb begin
      wr_data = wr_en_i && (addr_i == OFS_DATA);
      wr_dir  = wr_en_i && (addr_i == OFS_DIR);
      wr_mode = wr_en_i && (addr_i == OFS_MODE);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         data_q <= DATA_RST;
         dir_q  <= DIR_RST;
         mode_q <= MODE_RST;
      end else begin
         if (wr_data) data_q <= wdata_i;
         if (wr_dir)  dir_q  <= wdata_i;
         if (wr_mode) mode_q <= wdata_i;
      end
   end

   assert_reset_values_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(!rst_ni) |-> (data_q == DATA_RST && dir_q == DIR_RST && mode_q == MODE_RST));

   assert_data_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == OFS_DATA) |=> (data_q == $past(wdata_i)));

   assert_mask_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (addr_i == OFS_DIR || addr_i == OFS_MODE)) |=>
      ((dir_q == $past(wdata_i)) || (mode_q == $past(wdata_i))));

   assert_reserved_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == OFS_RSVD) |=> $stable({data_q, dir_q, mode_q}));
endmodule

// File: rtl/gpio_fsel_sync.sv
module gpio_fsel_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_fsel_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gpio_fsel_sync: W must be at least 1");
   end

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    stg_q[s] <= '0;
         else if (s == 0) stg_q[s] <= async_i;
         else            stg_q[s] <= stg_q[(s == 0) ? 0 : s - 1];
      end
   end

   assign sync_o = stg_q[LAST];
endmodule

// File: rtl/gpio_fsel_pinmux.sv
module gpio_fsel_pinmux #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] data_i,
   input  logic [W-1:0] dir_i,
   input  logic [W-1:0] mode_i,
   input  logic [W-1:0] sync_i,
   output logic [W-1:0] pin_o,
   output logic [W-1:0] pin_oe_o,
   output logic [W-1:0] fn_req_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_comb begin
         pin_o[i]    = data_i[i];
         pin_oe_o[i] = mode_i[i] & dir_i[i];
         fn_req_o[i] = mode_i[i] ? 1'b0 : sync_i[i];
      end

      assert_oe_gpio_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         pin_oe_o[i] |-> (mode_i[i] && dir_i[i]));

      assert_req_quiet_gpio_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         mode_i[i] |-> !fn_req_o[i]);
   end
endmodule

// File: rtl/gpio_fsel_port.sv
module gpio_fsel_port
   import gpio_fsel_pkg::*;
#(
   parameter int unsigned  PORT_W      = 8,
   parameter int unsigned  SYNC_STAGES = 2,
   parameter logic [PORT_W-1:0] DATA_RST = '1,
   parameter logic [PORT_W-1:0] DIR_RST  = '0,
   parameter logic [PORT_W-1:0] MODE_RST = '1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  wr_en_i,
   input  logic [REG_ADDR_W-1:0] addr_i,
   input  logic [PORT_W-1:0]     wdata_i,
   output logic [PORT_W-1:0]     rdata_o,
   input  logic [PORT_W-1:0]     pin_i,
   output logic [PORT_W-1:0]     pin_o,
   output logic [PORT_W-1:0]     pin_oe_o,
   output logic [PORT_W-1:0]     fn_req_o
);
   if (PORT_W < 1 || PORT_W > 64) begin : g_bad_port_w
      $error("gpio_fsel_port: PORT_W out of range");
   end

   logic [PORT_W-1:0] data_q, dir_q, mode_q, pin_sync;

   gpio_fsel_regs #(
      .W(PORT_W), .DATA_RST(DATA_RST), .DIR_RST(DIR_RST), .MODE_RST(MODE_RST)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .data_q(data_q), .dir_q(dir_q), .mode_q(mode_q)
   );

   gpio_fsel_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .async_i(pin_i), .sync_o(pin_sync)
   );

   // Bit i of fn_req_o is pin i's fixed dedicated line (R7): bits 0-3 are
   // interrupt inputs 0-3, bits 4-7 are interrupt levels 1, 2, 3 and 6.
   gpio_fsel_pinmux #(.W(PORT_W)) u_mux (
      .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_q), .dir_i(dir_q),
      .mode_i(mode_q), .sync_i(pin_sync), .pin_o(pin_o),
      .pin_oe_o(pin_oe_o), .fn_req_o(fn_req_o)
   );

   // Data offset returns the live synchronised pad level, never the latch (R5).
   always_comb begin
      unique case (addr_i)
         OFS_DATA: rdata_o = pin_sync;
         OFS_DIR:  rdata_o = dir_q;
         OFS_MODE: rdata_o = mode_q;
         default:  rdata_o = '0;
      endcase
   end
endmodule

// File: tb/test_gpio_fsel_port.sv
module test_gpio_fsel_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] ext = 8'hA5;
   logic [7:0] rdata, pin_o, pin_oe, fn_req, pad;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   // Pad: driven bits follow the port, the rest follow the external level.
   assign pad = (pin_oe & pin_o) | (~pin_oe & ext);

   gpio_fsel_port i_gpio_fsel_port (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .pin_i(pad), .pin_o(pin_o),
      .pin_oe_o(pin_oe), .fn_req_o(fn_req)
   );

   // Behavioural reference model
   int m_data, m_dir, m_mode;
   int hist[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_data = 8'hFF; m_dir = 0; m_mode = 8'hFF;
         hist = '{0, 0};
      end else begin
         if (wr_en && addr == 2'd0) m_data = wdata;
         if (wr_en && addr == 2'd1) m_dir  = wdata;
         if (wr_en && addr == 2'd2) m_mode = wdata;
         hist.push_back(int'(pad));
         void'(hist.pop_front());
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s act=%02h exp=%02h at %0t", req, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int exp_rd;
         case (addr)
            2'd0: exp_rd = hist[0];
            2'd1: exp_rd = m_dir;
            2'd2: exp_rd = m_mode;
            default: exp_rd = 0;
         endcase
         chk("R5/R8/R2 rdata", int'(rdata), exp_rd);
         chk("R4 pin_o", int'(pin_o), m_data);
         chk("R3 pin_oe", int'(pin_oe), m_dir & m_mode);
         chk("R6 fn_req", int'(fn_req), hist[0] & ~m_mode & 8'hFF);
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); #1 wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); #1 wr_en = 1'b0;
   endtask

   task automatic idle(input int n, input logic [1:0] a);
      @(negedge clk); #1 addr = a;
      repeat (n) @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); #1 rst_n = 1'b1;
      // R1: reset state
      @(negedge clk); #2;
      chk("R1 pin_o", int'(pin_o), 8'hFF);
      chk("R1 pin_oe", int'(pin_oe), 8'h00);
      chk("R1 fn_req", int'(fn_req), 8'h00);
      idle(1, 2'd1); chk("R1 dir", int'(rdata), 8'h00);
      idle(1, 2'd2); chk("R1 mode", int'(rdata), 8'hFF);

      // R4: write to input bits is stored but not driven
      wr(2'd0, 8'h3C);
      idle(3, 2'd0);
      chk("R4 latch kept", int'(pin_o), 8'h3C);
      chk("R4 not driven", int'(pin_oe), 8'h00);
      chk("R5 reads pad not latch", int'(rdata), 8'hA5);
      // R8 / R4 / R5: enable low nibble as outputs
      wr(2'd1, 8'h0F);
      idle(1, 2'd1); chk("R8 dir readback", int'(rdata), 8'h0F);
      idle(3, 2'd0);
      chk("R4 R5 driven latch read back", int'(rdata), 8'hAC);

      // R6 R7: low nibble to dedicated interrupt inputs 0-3
      wr(2'd2, 8'hF0);
      idle(1, 2'd2); chk("R8 mode readback", int'(rdata), 8'hF0);
      idle(3, 2'd0);
      chk("R3 dedicated undriven", int'(pin_oe), 8'h00);
      chk("R7 int0-3 lines", int'(fn_req), 8'h05);
      @(negedge clk); #1 ext = 8'h5A;
      idle(3, 2'd0);
      chk("R6 follows pad", int'(fn_req), 8'h0A);
      // R7: upper nibble to interrupt levels 1,2,3,6
      wr(2'd2, 8'h0F);
      @(negedge clk); #1 ext = 8'h90;
      idle(3, 2'd0);
      chk("R7 level lines", int'(fn_req), 8'h90);
      chk("R3 gpio outputs", int'(pin_oe), 8'h0F);

      // R2: reserved offset
      wr(2'd3, 8'h00);
      idle(1, 2'd3); chk("R2 reads zero", int'(rdata), 8'h00);
      chk("R2 latch unchanged", int'(pin_o), 8'h3C);
      idle(1, 2'd1); chk("R2 dir unchanged", int'(rdata), 8'h0F);

      // Random traffic, model compared every cycle
      for (int k = 0; k < 600; k++) begin
         @(negedge clk); #1;
         wr_en = ($urandom_range(0, 3) == 0);
         addr  = 2'($urandom_range(0, 3));
         wdata = 8'($urandom);
         if ($urandom_range(0, 2) == 0) ext = 8'($urandom);
      end
      @(negedge clk); #1 wr_en = 1'b0;
      idle(4, 2'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog act=running exp=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule